// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block is the sequencing engine of one channel of a scatter-gather transfer unit. Software places a chain of 8-byte descriptors in memory, then points the channel at the first one. The walker fetches each descriptor through a request/response read port and checks it. For every transfer entry it hands one burst command (buffer address and byte length) to a data mover. It moves on to the next descriptor, which sits 8 bytes further on. The walk ends at the entry marked last, at a malformed entry, or when software withdraws the enable of a receive channel. The end is marked by a one-cycle done pulse.

A static strap selects the channel flavour. A transmit channel launches as soon as its low list-pointer register is written. A receive channel launches only when bit 0 of its enable register is written as 1. Clearing that bit stops the receive channel at the next descriptor boundary.

The descriptor read request, the descriptor response and the burst command are valid/ready streams. A sender keeps valid high and its payload unchanged until the cycle in which ready is high. Only that cycle moves the item. The walker never drops a raised valid. It raises the response ready only while it waits for a descriptor. The data mover can stall a burst command for any number of cycles.

Top module: `sg_chain_walker`

## Requirements
- R1: A descriptor arrives as 64 bits in little-endian byte order. Bits 63:32 (bytes 4 to 7) are the buffer address and bits 31:16 (bytes 2 and 3) are the byte length. Each transfer entry produces exactly one burst command carrying that address and length.
- R2: The first fetch uses the 64-bit address {high pointer, low pointer}. Each following fetch uses the previous fetch address plus 8.
- R3: An entry with bit 1 set (the last flag) ends the walk once its burst command is accepted. After that there is a single-cycle done pulse with err low.
- R4: If a fetched descriptor has bit 0 (valid) clear, the walker issues no burst, sets err and ends the walk with a done pulse.
- R5: A transfer entry whose length is zero or not a multiple of 4 issues no burst, sets err and ends the walk. Every burst command has a nonzero length that is a multiple of 4.
- R6: A valid entry with bit 5 (transfer) clear issues no burst. The walk then moves to the next descriptor, or ends without error if that entry also carries the last flag.
- R7: With rx_mode low, a write to the low pointer starts the walk, and enable writes have no effect.
- R8: With rx_mode high, a write to the low pointer does not start the walk, and writing 1 to enable bit 0 does. Writing 0 to that bit during a walk stops it before the next descriptor fetch, and then done pulses with err low.
- R9: busy rises in the cycle after the start write and stays high through the done cycle, then falls. Start requests and pointer writes made while busy are ignored.
- R10: dreq_valid and mv_valid stay high, with their payloads unchanged, until accepted.
- R11: err stays high after an error end until the next walk starts, and the start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_mode | input | 1 | Static strap: 1 = receive channel, 0 = transmit channel |
| ptr_hi_wr | input | 1 | Write strobe, high list-pointer register |
| ptr_lo_wr | input | 1 | Write strobe, low list-pointer register |
| en_wr | input | 1 | Write strobe, enable register (bit 0 used) |
| wr_data | input | 32 | Write data for the three registers |
| dreq_valid | output | 1 | Descriptor read request valid |
| dreq_ready | input | 1 | Descriptor read request ready |
| dreq_addr | output | 64 | Descriptor byte address |
| drsp_valid | input | 1 | Descriptor response valid |
| drsp_ready | output | 1 | Descriptor response ready |
| drsp_data | input | 64 | Descriptor contents, byte 0 in bits 7:0 |
| mv_valid | output | 1 | Burst command valid |
| mv_ready | input | 1 | Burst command ready |
| mv_addr | output | 32 | Burst buffer address |
| mv_len | output | 16 | Burst length in bytes |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| err | output | 1 | Last walk ended on a malformed descriptor |

## Verification
Properties checked on every cycle:
- Stalled requests and burst commands keep their valid and payload until accepted.
- Every burst leaving the block has a legal, word-multiple length, and none appears while err is high.
- err can only rise together with the done pulse.
- done lasts one cycle and drops busy with it.
- busy only rises after an accepted start.

Only the directed scenarios can show the rest:
- That the right fields reach the mover and the fetch addresses step by 8.
- That non-transfer entries are skipped.
- That pointer and start writes during a walk change nothing.
- That a receive channel needs its enable bit and stops exactly one descriptor after the bit is cleared.

// File: rtl/sgw_pkg.sv
`timescale 1ns/1ps
package sgw_pkg;
  localparam int DESC_BYTES = 8;
  localparam int DESC_W     = DESC_BYTES * 8;
  localparam int BUF_AW     = 32;
  localparam int LEN_W      = 16;
  localparam int LEN_LSB    = 16;
  localparam int ADDR_LSB   = 32;
  localparam int FLAG_VALID = 0;
  localparam int FLAG_LAST  = 1;
  localparam int FLAG_XFER  = 5;

  typedef struct packed {
    logic [BUF_AW-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic              valid;
    logic              last;
    logic              xfer;
  } desc_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LAUNCH, ST_FETCH, ST_WAIT, ST_DECODE, ST_ISSUE, ST_DONE
  } walk_st_e;
endpackage

// File: rtl/sgw_desc_decode.sv
`timescale 1ns/1ps
module sgw_desc_decode
  import sgw_pkg::*;
#(
  parameter int ALIGN_BYTES = 4
) (
  input  logic [DESC_W-1:0] raw,
  output desc_t             fld,
  output logic              bad
);
  localparam int AL_BITS = $clog2(ALIGN_BYTES);

  logic [LEN_W-1:0] len_w;
  logic             misal;
  logic             unused_bits;

  assign len_w = raw[LEN_LSB +: LEN_W];

  generate
    if (AL_BITS > 0) begin : g_align
      assign misal = |len_w[AL_BITS-1:0];
    end else begin : g_noalign
      assign misal = 1'b0;
    end
  endgenerate

  always_comb begin
    fld.addr  = raw[ADDR_LSB +: BUF_AW];
    fld.len   = len_w;
    fld.valid = raw[FLAG_VALID];
    fld.last  = raw[FLAG_LAST];
    fld.xfer  = raw[FLAG_XFER];
    bad       = !raw[FLAG_VALID] || (raw[FLAG_XFER] && ((len_w == '0) || misal));
  end

  // reserved byte and spare flag bits are not decoded
  assign unused_bits = ^{raw[15:8], raw[7:6], raw[4:2]};
endmodule

// File: rtl/sgw_ptr_regs.sv
`timescale 1ns/1ps
module sgw_ptr_regs #(
  parameter int WORD_W = 32,
  localparam int PTR_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_mode,
  input  logic              ptr_hi_wr,
  input  logic              ptr_lo_wr,
  input  logic              en_wr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              busy,
  input  logic              walk_end,
  output logic              start,
  output logic [PTR_W-1:0]  start_ptr,
  output logic              stop_req
);
  logic [WORD_W-1:0] hi_q, lo_q;
  logic              en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
      en_q <= 1'b0;
    end else begin
      if (ptr_hi_wr && !busy) hi_q <= wr_data;
      if (ptr_lo_wr && !busy) lo_q <= wr_data;
      if (walk_end)                en_q <= 1'b0;
      else if (en_wr && rx_mode)   en_q <= wr_data[0];
    end
  end

  // transmit launches on the low-pointer write (new value bypassed),
  // receive launches on an enable write of 1
  always_comb begin
    start     = !busy && (rx_mode ? (en_wr && wr_data[0]) : ptr_lo_wr);
    start_ptr = {hi_q, (rx_mode ? lo_q : wr_data)};
    stop_req  = rx_mode && !en_q;
  end
endmodule

// File: rtl/sgw_walk_seq.sv
`timescale 1ns/1ps
module sgw_walk_seq
  import sgw_pkg::*;
#(
  parameter int PTR_W       = 64,
  parameter int ALIGN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PTR_W-1:0]  start_ptr,
  input  logic              stop_req,
  output logic              dreq_valid,
  input  logic              dreq_ready,
  output logic [PTR_W-1:0]  dreq_addr,
  input  logic              drsp_valid,
  output logic              drsp_ready,
  input  logic [DESC_W-1:0] drsp_data,
  output logic              mv_valid,
  input  logic              mv_ready,
  output logic [BUF_AW-1:0] mv_addr,
  output logic [LEN_W-1:0]  mv_len,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam logic [PTR_W-1:0] STEP = PTR_W'(DESC_BYTES);

  walk_st_e          st_q, st_d;
  logic [PTR_W-1:0]  cur_q;
  logic [DESC_W-1:0] desc_q;
  logic              err_q;
  logic              advance;
  desc_t             fld;
  logic              bad;

  sgw_desc_decode #(.ALIGN_BYTES(ALIGN_BYTES)) u_dec (
    .raw (desc_q),
    .fld (fld),
    .bad (bad)
  );

  always_comb begin
    st_d    = st_q;
    advance = 1'b0;
    case (st_q)
      ST_IDLE:   if (start) st_d = ST_LAUNCH;
      ST_LAUNCH: st_d = stop_req ? ST_DONE : ST_FETCH;
      ST_FETCH:  if (dreq_ready) st_d = ST_WAIT;
      ST_WAIT:   if (drsp_valid) st_d = ST_DECODE;
      ST_DECODE: begin
        if (bad)            st_d = ST_DONE;
        else if (fld.xfer)  st_d = ST_ISSUE;
        else if (fld.last)  st_d = ST_DONE;
        else begin
          st_d    = ST_LAUNCH;
          advance = 1'b1;
        end
      end
      ST_ISSUE: begin
        if (mv_ready) begin
          if (fld.last) st_d = ST_DONE;
          else begin
            st_d    = ST_LAUNCH;
            advance = 1'b1;
          end
        end
      end
      ST_DONE:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      desc_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start) begin
        cur_q <= start_ptr;
        err_q <= 1'b0;
      end else if (advance) begin
        cur_q <= cur_q + STEP;
      end
      if (st_q == ST_WAIT && drsp_valid) desc_q <= drsp_data;
      if (st_q == ST_DECODE && bad)      err_q  <= 1'b1;
    end
  end

  always_comb begin
    dreq_valid = (st_q == ST_FETCH);
    dreq_addr  = cur_q;
    drsp_ready = (st_q == ST_WAIT);
    mv_valid   = (st_q == ST_ISSUE);
    mv_addr    = fld.addr;
    mv_len     = fld.len;
    busy       = (st_q != ST_IDLE);
    done       = (st_q == ST_DONE);
    err        = err_q;
  end

  // R10: stalled streams hold valid and payload
  p_fetch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_valid && !dreq_ready |=> dreq_valid && $stable(dreq_addr));
  p_burst_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid && !mv_ready |=> mv_valid && $stable(mv_addr) && $stable(mv_len));
  // R3: done is a single-cycle pulse that ends the walk
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  // R5: every burst length is legal
  p_burst_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> (mv_len != '0) && ((mv_len % LEN_W'(ALIGN_BYTES)) == '0));
  // R4: no burst is issued once an error is flagged, and err rises only at the end
  p_clean_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> !err);
  p_err_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
  // R9: busy rises only after an accepted start
  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/sg_chain_walker.sv
`timescale 1ns/1ps
module sg_chain_walker
  import sgw_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int ALIGN_BYTES = 4,
  localparam int PTR_W      = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_mode,
  input  logic              ptr_hi_wr,
  input  logic              ptr_lo_wr,
  input  logic              en_wr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              dreq_valid,
  input  logic              dreq_ready,
  output logic [PTR_W-1:0]  dreq_addr,
  input  logic              drsp_valid,
  output logic              drsp_ready,
  input  logic [DESC_W-1:0] drsp_data,
  output logic              mv_valid,
  input  logic              mv_ready,
  output logic [BUF_AW-1:0] mv_addr,
  output logic [LEN_W-1:0]  mv_len,
  output logic              busy,
  output logic              done,
  output logic              err
);
  logic             start;
  logic [PTR_W-1:0] start_ptr;
  logic             stop_req;

  sgw_ptr_regs #(.WORD_W(WORD_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_mode   (rx_mode),
    .ptr_hi_wr (ptr_hi_wr),
    .ptr_lo_wr (ptr_lo_wr),
    .en_wr     (en_wr),
    .wr_data   (wr_data),
    .busy      (busy),
    .walk_end  (done),
    .start     (start),
    .start_ptr (start_ptr),
    .stop_req  (stop_req)
  );

  sgw_walk_seq #(.PTR_W(PTR_W), .ALIGN_BYTES(ALIGN_BYTES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_ptr  (start_ptr),
    .stop_req   (stop_req),
    .dreq_valid (dreq_valid),
    .dreq_ready (dreq_ready),
    .dreq_addr  (dreq_addr),
    .drsp_valid (drsp_valid),
    .drsp_ready (drsp_ready),
    .drsp_data  (drsp_data),
    .mv_valid   (mv_valid),
    .mv_ready   (mv_ready),
    .mv_addr    (mv_addr),
    .mv_len     (mv_len),
    .busy       (busy),
    .done       (done),
    .err        (err)
  );
endmodule

// File: tb/sim_sg_chain_walker.sv
`timescale 1ns/1ps
module sim_sg_chain_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_mode = 1'b0;
  logic        ptr_hi_wr = 1'b0, ptr_lo_wr = 1'b0, en_wr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        dreq_valid, drsp_ready, mv_valid, busy, done, err;
  logic        dreq_ready = 1'b0, drsp_valid = 1'b0, mv_ready = 1'b0;
  logic [63:0] dreq_addr;
  logic [63:0] drsp_data = '0;
  logic [31:0] mv_addr;
  logic [15:0] mv_len;

  always #2.5 clk = ~clk;

  sg_chain_walker u0 (
    .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode),
    .ptr_hi_wr(ptr_hi_wr), .ptr_lo_wr(ptr_lo_wr), .en_wr(en_wr), .wr_data(wr_data),
    .dreq_valid(dreq_valid), .dreq_ready(dreq_ready), .dreq_addr(dreq_addr),
    .drsp_valid(drsp_valid), .drsp_ready(drsp_ready), .drsp_data(drsp_data),
    .mv_valid(mv_valid), .mv_ready(mv_ready), .mv_addr(mv_addr), .mv_len(mv_len),
    .busy(busy), .done(done), .err(err)
  );

  int n_chk = 0, n_bad = 0;
  logic [63:0] dmem [0:31];
  logic [63:0] f_log [0:63];
  logic [31:0] b_addr [0:63];
  logic [15:0] b_len [0:63];
  int n_fetch = 0, n_burst = 0, n_done = 0;
  int fr_wait = 0, mv_wait = 0;
  int fr_gap = 0, mv_gap = 0;

  // memory and mover models, synchronous, NBA only
  always @(posedge clk) begin
    if (!rst_n) begin
      dreq_ready <= 1'b0; drsp_valid <= 1'b0; mv_ready <= 1'b0;
      fr_wait <= 0; mv_wait <= 0;
    end else begin
      if (drsp_valid && drsp_ready) drsp_valid <= 1'b0;
      if (dreq_valid && dreq_ready) begin
        f_log[n_fetch & 63] <= dreq_addr;
        n_fetch    <= n_fetch + 1;
        drsp_valid <= 1'b1;
        drsp_data  <= dmem[dreq_addr[7:3]];
        dreq_ready <= 1'b0;
        fr_wait    <= 0;
      end else if (dreq_valid) begin
        dreq_ready <= (fr_wait >= fr_gap);
        fr_wait    <= fr_wait + 1;
      end
      if (mv_valid && mv_ready) begin
        b_addr[n_burst & 63] <= mv_addr;
        b_len[n_burst & 63]  <= mv_len;
        n_burst  <= n_burst + 1;
        mv_ready <= 1'b0;
        mv_wait  <= 0;
      end else if (mv_valid) begin
        mv_ready <= (mv_wait >= mv_gap);
        mv_wait  <= mv_wait + 1;
      end
      if (done) n_done <= n_done + 1;
    end
  end

  function automatic logic [63:0] mk(input logic [31:0] a, input logic [15:0] l, input logic [7:0] f);
    return {a, l, 8'h00, f};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int which, input logic [31:0] v);
    @(negedge clk);
    wr_data = v; ptr_hi_wr = (which == 0); ptr_lo_wr = (which == 1); en_wr = (which == 2);
    @(negedge clk);
    ptr_hi_wr = 1'b0; ptr_lo_wr = 1'b0; en_wr = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    while (!done && t < 4000) begin @(negedge clk); t++; end
    chk({tag, " done seen"}, done, 1'b1);
    chk({tag, " busy during done (R9)"}, busy, 1'b1);
    @(negedge clk);
    chk({tag, " done single cycle (R3)"}, done, 1'b0);
    chk({tag, " busy falls after done (R9)"}, busy, 1'b0);
  endtask

  task automatic load_chain3();
    dmem[8]  = mk(32'h1000_0000, 16'h0010, 8'h21);
    dmem[9]  = mk(32'hA5B6_C7D8, 16'h0100, 8'h21);
    dmem[10] = mk(32'h0000_0FF0, 16'hFFFC, 8'h23);
  endtask

  task automatic t_reset();
    chk("R9 busy at reset", busy, 1'b0);
    chk("R3 done at reset", done, 1'b0);
    chk("R11 err at reset", err, 1'b0);
    chk("R10 dreq_valid at reset", dreq_valid, 1'b0);
    chk("R10 mv_valid at reset", mv_valid, 1'b0);
  endtask

  task automatic t_tx_chain(input int fgap, input int bgap, input logic [31:0] hi);
    int f0 = n_fetch, b0 = n_burst, d0 = n_done;
    fr_gap = fgap; mv_gap = bgap; rx_mode = 1'b0;
    load_chain3();
    wr(0, hi);
    chk("R7 hi write does not start", busy, 1'b0);
    wr(1, 32'h40);
    chk("R7 lo write starts tx walk", busy, 1'b1);
    wait_done("R3 tx chain");
    chk("R3 err clean end", err, 1'b0);
    chk("R3 one done", n_done - d0, 1);
    chk("R1 burst count", n_burst - b0, 3);
    chk("R1 burst0 addr", b_addr[b0 & 63], 32'h1000_0000);
    chk("R1 burst0 len", b_len[b0 & 63], 16'h0010);
    chk("R1 burst1 addr", b_addr[(b0 + 1) & 63], 32'hA5B6_C7D8);
    chk("R1 burst1 len", b_len[(b0 + 1) & 63], 16'h0100);
    chk("R1 burst2 addr", b_addr[(b0 + 2) & 63], 32'h0000_0FF0);
    chk("R1 burst2 len max", b_len[(b0 + 2) & 63], 16'hFFFC);
    chk("R2 fetch count", n_fetch - f0, 3);
    chk("R2 fetch0", f_log[f0 & 63], {hi, 32'h40});
    chk("R2 fetch1", f_log[(f0 + 1) & 63], {hi, 32'h48});
    chk("R2 fetch2", f_log[(f0 + 2) & 63], {hi, 32'h50});
  endtask

  task automatic t_invalid();
    int b0 = n_burst, f0 = n_fetch;
    fr_gap = 0; mv_gap = 0; rx_mode = 1'b0;
    dmem[8] = mk(32'h2000, 16'h0008, 8'h21);
    dmem[9] = mk(32'h3000, 16'h0008, 8'h20);
    wr(0, 32'h0);
    wr(1, 32'h40);
    wait_done("R4 invalid entry");
    chk("R4 err set", err, 1'b1);
    chk("R4 bursts before invalid", n_burst - b0, 1);
    chk("R4 fetches", n_fetch - f0, 2);
  endtask

  task automatic t_badlen(input logic [15:0] l, input string tag);
    int b0 = n_burst;
    dmem[8] = mk(32'h4000, l, 8'h23);
    wr(1, 32'h40);
    wait_done(tag);
    chk({tag, " err set (R5)"}, err, 1'b1);
    chk({tag, " no burst (R5)"}, n_burst - b0, 0);
    repeat (5) @(negedge clk);
    chk({tag, " err sticky (R11)"}, err, 1'b1);
  endtask

  task automatic t_err_clear();
    load_chain3();
    wr(1, 32'h40);
    chk("R11 err cleared by start", err, 1'b0);
    wait_done("R11 good walk");
    chk("R11 err low after good walk", err, 1'b0);
  endtask

  task automatic t_skip();
    int b0 = n_burst, f0 = n_fetch;
    dmem[8]  = mk(32'h5000, 16'h0000, 8'h01);
    dmem[9]  = mk(32'h6000, 16'h0020, 8'h21);
    dmem[10] = mk(32'h7000, 16'h0003, 8'h03);
    wr(1, 32'h40);
    wait_done("R6 skip entries");
    chk("R6 err low", err, 1'b0);
    chk("R6 one burst", n_burst - b0, 1);
    chk("R6 burst addr", b_addr[b0 & 63], 32'h6000);
    chk("R6 fetches", n_fetch - f0, 3);
  endtask

  task automatic t_tx_ignores_en();
    rx_mode = 1'b0;
    wr(2, 32'h1);
    repeat (3) @(negedge clk);
    chk("R7 enable write ignored in tx", busy, 1'b0);
  endtask

  task automatic t_rx_start();
    int b0 = n_burst;
    rx_mode = 1'b1; fr_gap = 1; mv_gap = 2;
    load_chain3();
    wr(1, 32'h40);
    repeat (3) @(negedge clk);
    chk("R8 lo write does not start rx", busy, 1'b0);
    wr(2, 32'h1);
    chk("R8 enable starts rx", busy, 1'b1);
    wait_done("R8 rx chain");
    chk("R8 rx bursts", n_burst - b0, 3);
    wr(1, 32'h40);
    repeat (3) @(negedge clk);
    chk("R8 enable self-clears at end", busy, 1'b0);
  endtask

  task automatic t_rx_stop();
    int b0 = n_burst, f0 = n_fetch;
    int t = 0;
    rx_mode = 1'b1; fr_gap = 0; mv_gap = 0;
    dmem[8]  = mk(32'h8000, 16'h0010, 8'h21);
    dmem[9]  = mk(32'h8100, 16'h0010, 8'h21);
    dmem[10] = mk(32'h8200, 16'h0010, 8'h21);
    dmem[11] = mk(32'h8300, 16'h0010, 8'h23);
    wr(1, 32'h40);
    wr(2, 32'h1);
    while (n_burst - b0 < 1 && t < 2000) begin @(negedge clk); t++; end
    wr(2, 32'h0);
    wait_done("R8 rx stop");
    chk("R8 stop err low", err, 1'b0);
    chk("R8 bursts before stop", n_burst - b0, 2);
    chk("R8 fetches before stop", n_fetch - f0, 2);
  endtask

  task automatic t_busy_ignore();
    int f0 = n_fetch, d0 = n_done, f1;
    rx_mode = 1'b0; fr_gap = 0; mv_gap = 8;
    load_chain3();
    wr(0, 32'h0);
    wr(1, 32'h40);
    wr(1, 32'h80);
    wr(0, 32'h7);
    wait_done("R9 busy ignore");
    chk("R9 one done", n_done - d0, 1);
    chk("R9 fetch2 unaffected", f_log[(f0 + 2) & 63], 64'h50);
    f1 = n_fetch;
    wr(1, 32'h40);
    wait_done("R9 after ignore");
    chk("R9 hi write ignored while busy", f_log[f1 & 63], 64'h40);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) dmem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_chain(0, 0, 32'h0);
    t_tx_chain(2, 5, 32'h1);
    t_invalid();
    t_badlen(16'h0006, "R5 misaligned len");
    t_badlen(16'h0000, "R5 zero len");
    t_err_clear();
    t_skip();
    t_tx_ignores_en();
    t_rx_start();
    t_rx_stop();
    t_busy_ignore();
    repeat (5) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule